// File: doc/BRIEF.md
# Atomic Conditional-Store Access Checker

Before a compare-and-swap store is allowed to proceed, this block decides whether the access is legal. It receives the outcome of the address translation for the access: a translation cause code (zero means the lookup succeeded), the page's read and write permission bits, and the page's cache attribute class. It also receives a small atomic-policy control word and a configuration flag that says whether a data cache is present.

Checks are applied in a fixed priority. A translation fault wins and is passed through unchanged. A page without both read and write permission is reported as store-prohibited. Only then is the cache attribute considered. Each cacheable class selects its own 2-bit policy field from the control word, and a zero field forbids the atomic operation. The isolate class is always refused. Any remaining class passes.

One request is accepted per cycle on a valid strobe. The verdict is registered and appears one cycle later, together with the faulting virtual address. The block does not perform the memory operation.

Top module: `atomic_access_guard`

## Requirements
- R1: When `req_valid` is high and `xlat_code` is nonzero, the response reports a fault whose cause equals `xlat_code`, whatever the other inputs are.
- R2: When `xlat_code` is zero and either `rd_ok` or `wr_ok` is low, the response reports a fault with cause 29 (store-prohibited), whatever the cache attribute and control word are. The checker never produces any other permission cause.
- R3: The cache attribute class selects a policy field from `atomic_ctl`. Class 0 (uncached/bypass) selects bits [1:0], class 1 (write-through) selects bits [3:2], and class 2 (write-back) selects bits [5:4]. A nonzero selected field passes.
- R4: When the selected policy field is zero, the response reports a fault with cause 3 (load/store error).
- R5: With a data cache present, class 3 (isolate) always reports cause 3, whatever the control word is.
- R6: With `dcache_present` low, the bypass field `atomic_ctl[1:0]` decides the result for every attribute class, including isolate and classes 4 to 7.
- R7: With a data cache present, classes 4 to 7 pass without a fault.
- R8: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` was high. In a cycle after `req_valid` was low, `rsp_fault`, `rsp_cause` and `rsp_vaddr` keep their previous values.
- R9: A faulting response carries the request's `req_vaddr` on `rsp_vaddr`. A passing response has `rsp_fault` low, `rsp_cause` 0 and `rsp_vaddr` 0.
- R10: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one check per cycle |
| xlat_code | input | 6 | Translation result cause, 0 = success |
| rd_ok | input | 1 | Page grants read |
| wr_ok | input | 1 | Page grants write |
| cache_attr | input | ATTR_W (3) | Cache attribute class of the page |
| atomic_ctl | input | 6 | Three 2-bit atomic policy fields |
| dcache_present | input | 1 | Configuration: a data cache exists |
| req_vaddr | input | VA_W (32) | Virtual address of the access |
| rsp_valid | output | 1 | Verdict is valid this cycle |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 6 | Fault cause, 0 on pass |
| rsp_vaddr | output | VA_W (32) | Faulting address, 0 on pass |

## Verification
Every verdict comes out of a single register stage. Inputs presented before a rising edge with `req_valid` high therefore show up on the outputs right after that edge. The bench drives each request on a falling edge and samples the verdict on the following falling edge. It then withdraws the strobe, scrambles every other input, and samples one cycle later to confirm that `rsp_valid` has dropped and the verdict fields have held. The sweep covers every combination of permissions, attribute class, control word and cache flag, for a successful lookup and for two translation fault codes.

// File: rtl/aag_pkg.sv
package aag_pkg;
  localparam int CAUSE_W = 6;
  localparam logic [CAUSE_W-1:0] CAUSE_NONE         = 6'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_LS_ERROR     = 6'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE_DENIED = 6'd29;

  typedef enum logic [1:0] {
    VERDICT_PASS      = 2'd0,
    VERDICT_FIELD     = 2'd1,
    VERDICT_FORCE_ERR = 2'd2
  } cache_verdict_e;
endpackage

// File: rtl/aag_policy_sel.sv
module aag_policy_sel
  import aag_pkg::*;
#(
  parameter int ATTR_W     = 3,
  parameter int FIELD_W    = 2,
  parameter int NUM_FIELDS = 3
) (
  input  logic [ATTR_W-1:0]             attr,
  input  logic                          dcache_present,
  input  logic [NUM_FIELDS*FIELD_W-1:0] ctl,
  output cache_verdict_e                verdict,
  output logic                          field_zero
);
  localparam int NUM_CLASSES = 2 ** ATTR_W;
  localparam logic [ATTR_W-1:0] CLASS_BYPASS  = '0;
  localparam logic [ATTR_W-1:0] CLASS_ISOLATE = ATTR_W'(NUM_FIELDS);

  logic [NUM_CLASSES-1:0] zero_vec;
  logic [ATTR_W-1:0]      eff_attr;

  // one zero detector per policy field; classes beyond the fields never read it
  for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_zero
    if (i < NUM_FIELDS) begin : g_fld
      assign zero_vec[i] = (ctl[i*FIELD_W +: FIELD_W] == '0);
    end else begin : g_none
      assign zero_vec[i] = 1'b0;
    end
  end

  always_comb begin
    eff_attr   = dcache_present ? attr : CLASS_BYPASS;
    field_zero = zero_vec[eff_attr];
    if (eff_attr < CLASS_ISOLATE) begin
      verdict = VERDICT_FIELD;
    end else if (eff_attr == CLASS_ISOLATE) begin
      verdict = VERDICT_FORCE_ERR;
    end else begin
      verdict = VERDICT_PASS;
    end
  end
endmodule

// File: rtl/aag_decide.sv
module aag_decide
  import aag_pkg::*;
(
  input  logic [CAUSE_W-1:0] xlat_code,
  input  logic               rd_ok,
  input  logic               wr_ok,
  input  cache_verdict_e     verdict,
  input  logic               field_zero,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause
);
  always_comb begin
    fault = 1'b0;
    cause = CAUSE_NONE;
    if (xlat_code != CAUSE_NONE) begin
      fault = 1'b1;
      cause = xlat_code;
    end else if (!(rd_ok && wr_ok)) begin
      fault = 1'b1;
      cause = CAUSE_STORE_DENIED;
    end else begin
      unique case (verdict)
        VERDICT_FORCE_ERR: begin
          fault = 1'b1;
          cause = CAUSE_LS_ERROR;
        end
        VERDICT_FIELD: begin
          fault = field_zero;
          cause = field_zero ? CAUSE_LS_ERROR : CAUSE_NONE;
        end
        default: begin
          fault = 1'b0;
          cause = CAUSE_NONE;
        end
      endcase
    end
  end
endmodule

// File: rtl/atomic_access_guard.sv
module atomic_access_guard
  import aag_pkg::*;
#(
  parameter int ATTR_W     = 3,
  parameter int VA_W       = 32,
  parameter int FIELD_W    = 2,
  parameter int NUM_FIELDS = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [CAUSE_W-1:0]            xlat_code,
  input  logic                          rd_ok,
  input  logic                          wr_ok,
  input  logic [ATTR_W-1:0]             cache_attr,
  input  logic [NUM_FIELDS*FIELD_W-1:0] atomic_ctl,
  input  logic                          dcache_present,
  input  logic [VA_W-1:0]               req_vaddr,
  output logic                          rsp_valid,
  output logic                          rsp_fault,
  output logic [CAUSE_W-1:0]            rsp_cause,
  output logic [VA_W-1:0]               rsp_vaddr
);
  cache_verdict_e     verdict;
  logic               field_zero;
  logic               fault_d;
  logic [CAUSE_W-1:0] cause_d;
  logic [VA_W-1:0]    vaddr_d;

  logic               valid_q;
  logic               fault_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [VA_W-1:0]    vaddr_q;

  aag_policy_sel #(
    .ATTR_W    (ATTR_W),
    .FIELD_W   (FIELD_W),
    .NUM_FIELDS(NUM_FIELDS)
  ) u_sel (
    .attr          (cache_attr),
    .dcache_present(dcache_present),
    .ctl           (atomic_ctl),
    .verdict       (verdict),
    .field_zero    (field_zero)
  );

  aag_decide u_dec (
    .xlat_code (xlat_code),
    .rd_ok     (rd_ok),
    .wr_ok     (wr_ok),
    .verdict   (verdict),
    .field_zero(field_zero),
    .fault     (fault_d),
    .cause     (cause_d)
  );

  always_comb begin
    vaddr_d = fault_d ? req_vaddr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
      vaddr_q <= '0;
    end else if (req_valid) begin
      fault_q <= fault_d;
      cause_q <= cause_d;
      vaddr_q <= vaddr_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_fault = fault_q;
  assign rsp_cause = cause_q;
  assign rsp_vaddr = vaddr_q;
endmodule

// File: rtl/aag_checker.sv
module aag_checker
  import aag_pkg::*;
#(
  parameter int ATTR_W     = 3,
  parameter int VA_W       = 32,
  parameter int FIELD_W    = 2,
  parameter int NUM_FIELDS = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic [CAUSE_W-1:0]            xlat_code,
  input logic                          rd_ok,
  input logic                          wr_ok,
  input logic [ATTR_W-1:0]             cache_attr,
  input logic [NUM_FIELDS*FIELD_W-1:0] atomic_ctl,
  input logic                          dcache_present,
  input logic [VA_W-1:0]               req_vaddr,
  input logic                          rsp_valid,
  input logic                          rsp_fault,
  input logic [CAUSE_W-1:0]            rsp_cause,
  input logic [VA_W-1:0]               rsp_vaddr
);
  logic clean;
  assign clean = req_valid && (xlat_code == '0) && rd_ok && wr_ok;

  AST_XLAT_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (xlat_code != '0) |=> rsp_fault && (rsp_cause == $past(xlat_code))); // R1

  AST_PERM_STORE_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (xlat_code == '0) && !(rd_ok && wr_ok) |=> rsp_cause == CAUSE_STORE_DENIED); // R2

  AST_BYPASS_ZERO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    clean && (atomic_ctl[FIELD_W-1:0] == '0) && (!dcache_present || cache_attr == '0)
    |=> rsp_fault && (rsp_cause == CAUSE_LS_ERROR)); // R4

  AST_ISOLATE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    clean && dcache_present && (cache_attr == ATTR_W'(NUM_FIELDS))
    |=> rsp_cause == CAUSE_LS_ERROR); // R5

  AST_RSP_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R8

  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && $stable(rsp_fault) && $stable(rsp_cause) && $stable(rsp_vaddr)); // R8

  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> (rsp_cause == '0) && (rsp_vaddr == '0)); // R9

  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (xlat_code != '0) |=> rsp_vaddr == $past(req_vaddr)); // R9
endmodule

bind atomic_access_guard aag_checker #(
  .ATTR_W    (ATTR_W),
  .VA_W      (VA_W),
  .FIELD_W   (FIELD_W),
  .NUM_FIELDS(NUM_FIELDS)
) u_chk (.*);

// File: tb/sim_atomic_access_guard.sv
`timescale 1ns/1ps
module sim_atomic_access_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [5:0]  xlat_code;
  logic        rd_ok, wr_ok;
  logic [2:0]  cache_attr;
  logic [5:0]  atomic_ctl;
  logic        dcache_present;
  logic [31:0] req_vaddr;
  logic        rsp_valid, rsp_fault;
  logic [5:0]  rsp_cause;
  logic [31:0] rsp_vaddr;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  atomic_access_guard u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .xlat_code(xlat_code),
    .rd_ok(rd_ok), .wr_ok(wr_ok), .cache_attr(cache_attr), .atomic_ctl(atomic_ctl),
    .dcache_present(dcache_present), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_vaddr(rsp_vaddr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input int xl, input int rd, input int wr, input int ca,
                         input int ctl, input int dc, input logic [31:0] va);
    logic [5:0]  exp_cause;
    logic        exp_fault;
    logic [31:0] exp_va;
    int          field;
    string       tag;
    @(negedge clk);
    req_valid = 1'b1; xlat_code = 6'(xl); rd_ok = 1'(rd); wr_ok = 1'(wr);
    cache_attr = 3'(ca); atomic_ctl = 6'(ctl); dcache_present = 1'(dc); req_vaddr = va;
    if (xl != 0) begin
      tag = "R1"; exp_cause = 6'(xl);
    end else if (!(rd == 1 && wr == 1)) begin
      tag = "R2"; exp_cause = 6'd29;
    end else if (dc == 0) begin
      tag = "R6"; exp_cause = ((ctl & 3) == 0) ? 6'd3 : 6'd0;
    end else if (ca == 3) begin
      tag = "R5"; exp_cause = 6'd3;
    end else if (ca > 3) begin
      tag = "R7"; exp_cause = 6'd0;
    end else begin
      field = (ctl >> (2 * ca)) & 3;
      tag = (field == 0) ? "R4" : "R3";
      exp_cause = (field == 0) ? 6'd3 : 6'd0;
    end
    exp_fault = (exp_cause != 6'd0);
    exp_va    = exp_fault ? va : 32'd0;
    @(negedge clk);
    check(rsp_valid == 1'b1, "R8 rsp_valid after strobe", 32'(rsp_valid), 32'd1);
    check(rsp_fault == exp_fault && rsp_cause == exp_cause, tag,
          {25'd0, rsp_fault, rsp_cause}, {25'd0, exp_fault, exp_cause});
    check(rsp_vaddr == exp_va, "R9 address", rsp_vaddr, exp_va);
    req_valid = 1'b0; xlat_code = 6'd7; rd_ok = ~rd_ok; atomic_ctl = ~atomic_ctl;
    cache_attr = ~cache_attr; req_vaddr = ~va;
    @(negedge clk);
    check(rsp_valid == 1'b0 && rsp_fault == exp_fault && rsp_cause == exp_cause &&
          rsp_vaddr == exp_va, "R8 hold while idle",
          {rsp_vaddr[24:0], rsp_valid, rsp_cause}, {exp_va[24:0], 1'b0, exp_cause});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int xcodes[3] = '{0, 2, 17};
    logic [31:0] va;
    rst_n = 1'b0; req_valid = 1'b1; xlat_code = 6'd5; rd_ok = 1'b1; wr_ok = 1'b1;
    cache_attr = 3'd0; atomic_ctl = 6'd0; dcache_present = 1'b1; req_vaddr = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    check(rsp_valid == 0 && rsp_fault == 0 && rsp_cause == 0 && rsp_vaddr == 0,
          "R10 reset state", {rsp_vaddr[24:0], rsp_valid, rsp_cause}, 32'd0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    va = 32'h1357_9BDF;
    for (int xi = 0; xi < 3; xi++)
      for (int dc = 0; dc < 2; dc++)
        for (int rd = 0; rd < 2; rd++)
          for (int wr = 0; wr < 2; wr++)
            for (int ca = 0; ca < 8; ca++)
              for (int ctl = 0; ctl < 64; ctl++) begin
                va = va * 32'd1664525 + 32'd1013904223;
                run_vec(xcodes[xi], rd, wr, ca, ctl, dc, va);
              end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule